// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block keeps the control-flow state of one warp of four lanes that share a single program counter. It holds a stack of entries. Each entry carries a resume PC, an active lane mask and a join PC. The entry on top supplies the PC and the lane mask for the next fetch. Three kinds of event change that state: a plain PC update, a conditional branch whose per-lane outcome is given as a mask, and a transaction abort that names the lanes that have to re-run.

A branch on which the active lanes disagree splits the warp. The top entry stops at the join PC and keeps the full mask. Entries for the not-taken group and then the taken group are pushed above it, so the taken group runs first and the not-taken group runs next. When the running group's next PC equals its join PC, its entry is popped. Once both groups have been popped, the original mask resumes at the join point. A transaction abort goes through the same mechanism, in the way a loop back-edge would. The aborted lanes go back to the transaction-begin PC as a new entry. The lanes that committed wait at the resume PC, and that PC is also the join point for the re-run.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, cur_pc is RESET_PC (0), cur_mask is 4'b1111 (bit i is lane i), stk_depth is 1 and ovf_err is 0. The base entry's join PC is all ones.
- R2: With adv_valid alone, cur_pc becomes adv_pc one cycle later and the mask is unchanged, unless the pop of R5 applies. With no valid input, PC, mask and depth hold.
- R3: On a branch where every active lane agrees, nothing is pushed. cur_pc becomes br_target if all active lanes are set in br_taken, and br_fall if none are.
- R4: On a divergent branch where br_target and br_fall both differ from br_join, depth grows by 2. The next cycle shows br_target with mask br_taken AND the active mask.
- R5: When an update would set the top entry's PC equal to its join PC and depth is above 1, the entry is popped. The entry below then drives PC and mask, for example the not-taken group at br_fall with the remaining lanes.
- R6: Once both groups of a split have been popped, cur_pc equals br_join and cur_mask equals the mask held before the branch.
- R7: A group whose start PC already equals br_join gets no entry, so a divergent branch with br_fall equal to br_join grows depth by 1 only.
- R8: An abort acts as a branch with target ab_begin, taken mask ab_mask, and fall-through and join both ab_resume. If some active lanes abort, they run at ab_begin with depth plus 1. If all abort, the PC moves to ab_begin with no push. If none abort, the PC moves to ab_resume.
- R9: A divergent event that needs more than DEPTH entries leaves PC, mask and depth unchanged and sets ovf_err. ovf_err stays set until reset.
- R10: When several valid inputs are high together, abort takes priority over branch, and branch takes priority over advance. The lower-priority inputs have no effect.
- R11: At depth 1 no pop happens, even if the new PC equals the base join PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_valid | input | 1 | Plain PC update event |
| adv_pc | input | PC_W | Next PC for a plain update |
| br_valid | input | 1 | Branch outcome event |
| br_taken | input | LANES | Lanes whose condition is true |
| br_target | input | PC_W | PC of the taken path |
| br_fall | input | PC_W | PC of the not-taken path |
| br_join | input | PC_W | Reconvergence PC of the branch |
| ab_valid | input | 1 | Transaction abort event |
| ab_mask | input | LANES | Lanes whose transaction aborted |
| ab_begin | input | PC_W | Transaction-begin PC |
| ab_resume | input | PC_W | PC after the commit point |
| cur_pc | output | PC_W | PC of the top entry |
| cur_mask | output | LANES | Active lanes of the top entry |
| stk_depth | output | $clog2(DEPTH+1) | Number of valid entries |
| ovf_err | output | 1 | Sticky stack overflow flag |

## Verification
Every event is registered once, so its effect on cur_pc, cur_mask, stk_depth and ovf_err appears exactly one clock after the edge that captured it. A pop caused by reaching the join PC appears in that same cycle, not one later. The bench applies an event just after a falling edge and removes it at the next falling edge. At that falling edge, one posedge later, it compares all four outputs with its own stack model, so each check sees the result of exactly one event. The overflow case runs on a second instance with a shallow stack, because four lanes can never fill eight entries.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_ADV    = 2'd1,
        EV_BRANCH = 2'd2,
        EV_ABORT  = 2'd3
    } ev_kind_e;

    // Priority: abort over branch over plain update.
    function automatic ev_kind_e pick_event(input logic ab, input logic br, input logic adv);
        if (ab)       return EV_ABORT;
        else if (br)  return EV_BRANCH;
        else if (adv) return EV_ADV;
        else          return EV_NONE;
    endfunction

endpackage

// File: rtl/simt_div_split.sv
module simt_div_split
    import simt_reconv_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PC_W  = 16
) (
    input  ev_kind_e           kind,
    input  logic [LANES-1:0]   act_mask,
    input  logic [PC_W-1:0]    adv_pc,
    input  logic [LANES-1:0]   br_taken,
    input  logic [PC_W-1:0]    br_target,
    input  logic [PC_W-1:0]    br_fall,
    input  logic [PC_W-1:0]    br_join,
    input  logic [LANES-1:0]   ab_mask,
    input  logic [PC_W-1:0]    ab_begin,
    input  logic [PC_W-1:0]    ab_resume,
    output logic [LANES-1:0]   tk_mask,
    output logic [LANES-1:0]   nt_mask,
    output logic [PC_W-1:0]    tgt_pc,
    output logic [PC_W-1:0]    fall_pc,
    output logic [PC_W-1:0]    join_pc,
    output logic [PC_W-1:0]    uni_pc,
    output logic               diverge
);
    logic [LANES-1:0] raw_mask;

    always_comb begin
        raw_mask = '0;
        tgt_pc   = '0;
        fall_pc  = '0;
        join_pc  = '0;
        unique case (kind)
            EV_ABORT: begin
                // An abort behaves as a loop back-edge to the begin PC.
                raw_mask = ab_mask;
                tgt_pc   = ab_begin;
                fall_pc  = ab_resume;
                join_pc  = ab_resume;
            end
            EV_BRANCH: begin
                raw_mask = br_taken;
                tgt_pc   = br_target;
                fall_pc  = br_fall;
                join_pc  = br_join;
            end
            default: ;
        endcase

        tk_mask = raw_mask & act_mask;
        nt_mask = act_mask & ~raw_mask;
        diverge = (kind == EV_ABORT || kind == EV_BRANCH)
                  && (tk_mask != '0) && (nt_mask != '0);

        if (kind == EV_ADV)        uni_pc = adv_pc;
        else if (tk_mask != '0)    uni_pc = tgt_pc;
        else                       uni_pc = fall_pc;
    end

endmodule

// File: rtl/simt_push_plan.sv
module simt_push_plan #(
    parameter int LANES = 4,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic               diverge,
    input  logic [CW-1:0]      cnt,
    input  logic [LANES-1:0]   tk_mask,
    input  logic [LANES-1:0]   nt_mask,
    input  logic [PC_W-1:0]    tgt_pc,
    input  logic [PC_W-1:0]    fall_pc,
    input  logic [PC_W-1:0]    join_pc,
    output logic [1:0]         npush,
    output logic [PC_W-1:0]    e0_pc,
    output logic [LANES-1:0]   e0_mask,
    output logic [PC_W-1:0]    e1_pc,
    output logic [LANES-1:0]   e1_mask,
    output logic               ovf
);
    logic need_tk;
    logic need_nt;

    always_comb begin
        // A group already at the join PC needs no entry of its own.
        need_tk = (tgt_pc != join_pc);
        need_nt = (fall_pc != join_pc);
        npush   = {1'b0, need_tk} + {1'b0, need_nt};

        e0_pc   = '0;
        e0_mask = '0;
        e1_pc   = '0;
        e1_mask = '0;
        if (need_nt) begin
            // Not-taken below, taken on top: taken runs first.
            e0_pc   = fall_pc;
            e0_mask = nt_mask;
            e1_pc   = tgt_pc;
            e1_mask = tk_mask;
        end else if (need_tk) begin
            e0_pc   = tgt_pc;
            e0_mask = tk_mask;
        end

        ovf = diverge &&
              (({1'b0, cnt} + (CW + 1)'(npush)) > (CW + 1)'(DEPTH));
    end

endmodule

// File: rtl/simt_stack_regs.sv
module simt_stack_regs #(
    parameter int LANES    = 4,
    parameter int PC_W     = 16,
    parameter int DEPTH    = 8,
    parameter int RESET_PC = 0,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_top,
    input  logic [PC_W-1:0]    set_pc,
    input  logic               pop,
    input  logic [1:0]         npush,
    input  logic [PC_W-1:0]    push_join,
    input  logic [PC_W-1:0]    e0_pc,
    input  logic [LANES-1:0]   e0_mask,
    input  logic [PC_W-1:0]    e1_pc,
    input  logic [LANES-1:0]   e1_mask,
    output logic [PC_W-1:0]    top_pc,
    output logic [LANES-1:0]   top_mask,
    output logic [PC_W-1:0]    top_join,
    output logic [CW-1:0]      cnt
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [LANES-1:0] mask;
        logic [PC_W-1:0]  jpc;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CW-1:0]    cnt;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (set_top && (CW'(i) == st_q.cnt - CW'(1))) begin
                st_d.ent[i].pc = set_pc;
            end
            if ((npush != 2'd0) && (CW'(i) == st_q.cnt)) begin
                st_d.ent[i].pc   = e0_pc;
                st_d.ent[i].mask = e0_mask;
                st_d.ent[i].jpc  = push_join;
            end
            if ((npush == 2'd2) && (CW'(i) == st_q.cnt + CW'(1))) begin
                st_d.ent[i].pc   = e1_pc;
                st_d.ent[i].mask = e1_mask;
                st_d.ent[i].jpc  = push_join;
            end
        end
        st_d.cnt = st_q.cnt - CW'(pop) + CW'(npush);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.ent[0].pc   <= PC_W'(RESET_PC);
            st_q.ent[0].mask <= '1;
            st_q.ent[0].jpc  <= '1;
            st_q.cnt        <= CW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        top_pc   = '0;
        top_mask = '0;
        top_join = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) == st_q.cnt - CW'(1)) begin
                top_pc   = st_q.ent[i].pc;
                top_mask = st_q.ent[i].mask;
                top_join = st_q.ent[i].jpc;
            end
        end
        cnt = st_q.cnt;
    end

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_reconv_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int PC_W     = 16,
    parameter int DEPTH    = 8,
    parameter int RESET_PC = 0,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_valid,
    input  logic [PC_W-1:0]    adv_pc,
    input  logic               br_valid,
    input  logic [LANES-1:0]   br_taken,
    input  logic [PC_W-1:0]    br_target,
    input  logic [PC_W-1:0]    br_fall,
    input  logic [PC_W-1:0]    br_join,
    input  logic               ab_valid,
    input  logic [LANES-1:0]   ab_mask,
    input  logic [PC_W-1:0]    ab_begin,
    input  logic [PC_W-1:0]    ab_resume,
    output logic [PC_W-1:0]    cur_pc,
    output logic [LANES-1:0]   cur_mask,
    output logic [CW-1:0]      stk_depth,
    output logic               ovf_err
);
    typedef struct packed {
        logic err;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    ev_kind_e         kind;
    logic [PC_W-1:0]  top_pc;
    logic [LANES-1:0] top_mask;
    logic [PC_W-1:0]  top_join;
    logic [CW-1:0]    cnt;

    logic [LANES-1:0] tk_mask;
    logic [LANES-1:0] nt_mask;
    logic [PC_W-1:0]  tgt_pc;
    logic [PC_W-1:0]  fall_pc;
    logic [PC_W-1:0]  join_pc;
    logic [PC_W-1:0]  uni_pc;
    logic             diverge;

    logic [1:0]       plan_n;
    logic [PC_W-1:0]  e0_pc;
    logic [LANES-1:0] e0_mask;
    logic [PC_W-1:0]  e1_pc;
    logic [LANES-1:0] e1_mask;
    logic             plan_ovf;

    logic             set_top;
    logic [PC_W-1:0]  set_pc;
    logic             pop;
    logic [1:0]       npush;

    assign kind = pick_event(ab_valid, br_valid, adv_valid);

    simt_div_split #(.LANES(LANES), .PC_W(PC_W)) u_split (
        .kind      (kind),
        .act_mask  (top_mask),
        .adv_pc    (adv_pc),
        .br_taken  (br_taken),
        .br_target (br_target),
        .br_fall   (br_fall),
        .br_join   (br_join),
        .ab_mask   (ab_mask),
        .ab_begin  (ab_begin),
        .ab_resume (ab_resume),
        .tk_mask   (tk_mask),
        .nt_mask   (nt_mask),
        .tgt_pc    (tgt_pc),
        .fall_pc   (fall_pc),
        .join_pc   (join_pc),
        .uni_pc    (uni_pc),
        .diverge   (diverge)
    );

    simt_push_plan #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_plan (
        .diverge (diverge),
        .cnt     (cnt),
        .tk_mask (tk_mask),
        .nt_mask (nt_mask),
        .tgt_pc  (tgt_pc),
        .fall_pc (fall_pc),
        .join_pc (join_pc),
        .npush   (plan_n),
        .e0_pc   (e0_pc),
        .e0_mask (e0_mask),
        .e1_pc   (e1_pc),
        .e1_mask (e1_mask),
        .ovf     (plan_ovf)
    );

    always_comb begin
        ctl_d   = ctl_q;
        set_top = 1'b0;
        set_pc  = top_pc;
        pop     = 1'b0;
        npush   = 2'd0;
        if (kind != EV_NONE) begin
            if (!diverge) begin
                if ((uni_pc == top_join) && (cnt > CW'(1))) begin
                    pop = 1'b1;
                end else begin
                    set_top = 1'b1;
                    set_pc  = uni_pc;
                end
            end else if (plan_ovf) begin
                ctl_d.err = 1'b1;
            end else begin
                // Current entry parks at the join PC with its full mask.
                set_top = 1'b1;
                set_pc  = join_pc;
                npush   = plan_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    simt_stack_regs #(
        .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(RESET_PC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_top   (set_top),
        .set_pc    (set_pc),
        .pop       (pop),
        .npush     (npush),
        .push_join (join_pc),
        .e0_pc     (e0_pc),
        .e0_mask   (e0_mask),
        .e1_pc     (e1_pc),
        .e1_mask   (e1_mask),
        .top_pc    (top_pc),
        .top_mask  (top_mask),
        .top_join  (top_join),
        .cnt       (cnt)
    );

    assign cur_pc    = top_pc;
    assign cur_mask  = top_mask;
    assign stk_depth = cnt;
    assign ovf_err   = ctl_q.err;

endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
    parameter int LANES = 4,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adv_valid,
    input logic [PC_W-1:0]  adv_pc,
    input logic             br_valid,
    input logic             ab_valid,
    input logic [LANES-1:0] ab_mask,
    input logic [PC_W-1:0]  ab_begin,
    input logic [PC_W-1:0]  cur_pc,
    input logic [LANES-1:0] cur_mask,
    input logic [CW-1:0]    stk_depth,
    input logic             ovf_err
);
    // R1: the running entry always has at least one lane.
    p_mask_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cur_mask != '0);

    // R9: depth stays inside 1..DEPTH.
    p_depth_bounds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_depth >= CW'(1)) && (stk_depth <= CW'(DEPTH)));

    // R9: the overflow flag never clears without reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R2: a lone update lands its PC unless a pop happened.
    p_adv_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_valid && !br_valid && !ab_valid) |=>
        ((stk_depth != $past(stk_depth)) || (cur_pc == $past(adv_pc))));

    // R2: no event, no change.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_valid && !br_valid && !ab_valid) |=>
        ($stable(cur_pc) && $stable(cur_mask) && $stable(stk_depth)));

    // R4: a pushed group is a subset of the lanes that were running.
    p_push_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_depth > $past(stk_depth)) |->
        ((cur_mask & ~$past(cur_mask)) == '0));

    // R5: pops remove one entry per cycle.
    p_pop_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_depth < $past(stk_depth)) |->
        (stk_depth == $past(stk_depth) - CW'(1)));

    // R10 / R8: an abort covering every active lane wins and jumps to begin.
    p_abort_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_valid && ((ab_mask & cur_mask) == cur_mask)) |=>
        ((stk_depth != $past(stk_depth)) || (cur_pc == $past(ab_begin))));

endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
    .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_valid (adv_valid),
    .adv_pc    (adv_pc),
    .br_valid  (br_valid),
    .ab_valid  (ab_valid),
    .ab_mask   (ab_mask),
    .ab_begin  (ab_begin),
    .cur_pc    (cur_pc),
    .cur_mask  (cur_mask),
    .stk_depth (stk_depth),
    .ovf_err   (ovf_err)
);

// File: tb/test_simt_reconv_stack.sv
module test_simt_reconv_stack;
    localparam int LANES = 4;
    localparam int PC_W  = 16;
    localparam int MD    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            adv_valid = 0;
    logic [PC_W-1:0] adv_pc = 0;
    logic            br_valid = 0;
    logic [3:0]      br_taken = 0;
    logic [PC_W-1:0] br_target = 0, br_fall = 0, br_join = 0;
    logic            ab_valid = 0;
    logic [3:0]      ab_mask = 0;
    logic [PC_W-1:0] ab_begin = 0, ab_resume = 0;

    logic [PC_W-1:0] cur_pc, s_pc;
    logic [3:0]      cur_mask, s_mask;
    logic [3:0]      stk_depth;
    logic [2:0]      s_depth;
    logic            ovf_err, s_err;

    simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(MD)) i_simt_reconv_stack (
        .clk(clk), .rst_n(rst_n),
        .adv_valid(adv_valid), .adv_pc(adv_pc),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .br_fall(br_fall), .br_join(br_join),
        .ab_valid(ab_valid), .ab_mask(ab_mask), .ab_begin(ab_begin), .ab_resume(ab_resume),
        .cur_pc(cur_pc), .cur_mask(cur_mask), .stk_depth(stk_depth), .ovf_err(ovf_err)
    );

    // Shallow copy: four lanes cannot fill eight entries, so overflow is shown here.
    simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(4)) i_simt_reconv_stack_shallow (
        .clk(clk), .rst_n(rst_n),
        .adv_valid(adv_valid), .adv_pc(adv_pc),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .br_fall(br_fall), .br_join(br_join),
        .ab_valid(ab_valid), .ab_mask(ab_mask), .ab_begin(ab_begin), .ab_resume(ab_resume),
        .cur_pc(s_pc), .cur_mask(s_mask), .stk_depth(s_depth), .ovf_err(s_err)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Reference stack built from the requirements.
    logic [PC_W-1:0] m_pc   [16];
    logic [3:0]      m_mask [16];
    logic [PC_W-1:0] m_join [16];
    int              m_cnt;
    bit              m_err;

    task automatic model_reset();
        m_cnt = 1; m_err = 0;
        m_pc[0] = '0; m_mask[0] = 4'hF; m_join[0] = '1;
    endtask

    task automatic model_apply();
        int t;
        logic [3:0] act, raw, tk, nt;
        logic [PC_W-1:0] tg, fl, jn, up;
        bit is_adv, div;
        int np;
        t = m_cnt - 1;
        act = m_mask[t];
        is_adv = 0;
        if (ab_valid) begin
            raw = ab_mask; tg = ab_begin; fl = ab_resume; jn = ab_resume;
        end else if (br_valid) begin
            raw = br_taken; tg = br_target; fl = br_fall; jn = br_join;
        end else if (adv_valid) begin
            raw = 0; tg = 0; fl = 0; jn = 0; is_adv = 1;
        end else return;
        tk = raw & act; nt = act & ~raw;
        div = !is_adv && tk != 0 && nt != 0;
        up = is_adv ? adv_pc : (tk != 0 ? tg : fl);
        if (!div) begin
            if (up == m_join[t] && m_cnt > 1) m_cnt--;
            else m_pc[t] = up;
        end else begin
            np = int'(tg != jn) + int'(fl != jn);
            if (m_cnt + np > MD) m_err = 1;
            else begin
                m_pc[t] = jn;
                if (fl != jn) begin
                    m_pc[m_cnt] = fl; m_mask[m_cnt] = nt; m_join[m_cnt] = jn; m_cnt++;
                end
                if (tg != jn) begin
                    m_pc[m_cnt] = tg; m_mask[m_cnt] = tk; m_join[m_cnt] = jn; m_cnt++;
                end
            end
        end
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        int t;
        t = m_cnt - 1;
        check(cur_pc == m_pc[t], req, "pc", int'(cur_pc), int'(m_pc[t]));
        check(cur_mask == m_mask[t], req, "mask", int'(cur_mask), int'(m_mask[t]));
        check(int'(stk_depth) == m_cnt, req, "depth", int'(stk_depth), m_cnt);
        check(ovf_err == m_err, req, "err", int'(ovf_err), int'(m_err));
    endtask

    task automatic expect_main(string req, int pc, int mask, int depth);
        check(int'(cur_pc) == pc, req, "pc", int'(cur_pc), pc);
        check(int'(cur_mask) == mask, req, "mask", int'(cur_mask), mask);
        check(int'(stk_depth) == depth, req, "depth", int'(stk_depth), depth);
    endtask

    task automatic clear_in();
        adv_valid = 0; br_valid = 0; ab_valid = 0;
    endtask

    // Apply one event for one cycle; on return the outputs reflect it.
    task automatic fire();
        model_apply();
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_adv(int pc);
        adv_valid = 1; adv_pc = PC_W'(pc); fire();
    endtask

    task automatic do_br(int tk, int tg, int fl, int jn);
        br_valid = 1; br_taken = 4'(tk); br_target = PC_W'(tg);
        br_fall = PC_W'(fl); br_join = PC_W'(jn); fire();
    endtask

    task automatic do_ab(int m, int b, int r);
        ab_valid = 1; ab_mask = 4'(m); ab_begin = PC_W'(b); ab_resume = PC_W'(r); fire();
    endtask

    task automatic do_reset();
        rst_n = 0; clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        expect_main("R1", 0, 4'hF, 1);
        check(ovf_err == 0, "R1", "err", int'(ovf_err), 0);
        check_state("R1");

        // R2 plain update and idle hold
        do_adv(16'h0004); expect_main("R2", 16'h0004, 4'hF, 1);
        @(negedge clk);   expect_main("R2", 16'h0004, 4'hF, 1);

        // R3 uniform branch both ways
        do_br(4'hF, 16'h0040, 16'h0008, 16'h0050); expect_main("R3", 16'h0040, 4'hF, 1);
        do_br(4'h0, 16'h0070, 16'h0044, 16'h0050); expect_main("R3", 16'h0044, 4'hF, 1);

        // R11 base entry never pops
        do_adv(16'hFFFF); expect_main("R11", 16'hFFFF, 4'hF, 1);
        do_adv(16'h0050);

        // R4 split, R5 pop to not-taken group, R6 rejoin
        do_br(4'h3, 16'h0060, 16'h0070, 16'h0080); expect_main("R4", 16'h0060, 4'h3, 3);
        do_adv(16'h0064); expect_main("R4", 16'h0064, 4'h3, 3);
        do_adv(16'h0080); expect_main("R5", 16'h0070, 4'hC, 2);
        do_adv(16'h0080); expect_main("R6", 16'h0080, 4'hF, 1);

        // R7 not-taken already at the join: one push only
        do_br(4'h5, 16'h0090, 16'h00A0, 16'h00A0); expect_main("R7", 16'h0090, 4'h5, 2);
        do_adv(16'h00A0); expect_main("R7", 16'h00A0, 4'hF, 1);

        // R8 abort: partial, full re-run, none left
        do_ab(4'h6, 16'h0100, 16'h0120); expect_main("R8", 16'h0100, 4'h6, 2);
        do_adv(16'h0104);
        do_ab(4'h6, 16'h0100, 16'h0120); expect_main("R8", 16'h0100, 4'h6, 2);
        do_ab(4'h0, 16'h0100, 16'h0120); expect_main("R8", 16'h0120, 4'hF, 1);
        do_ab(4'hF, 16'h0100, 16'h0120); expect_main("R8", 16'h0100, 4'hF, 1);

        // R10 priority
        adv_valid = 1; adv_pc = 16'h0007;
        br_valid = 1; br_taken = 4'hF; br_target = 16'h0008; br_fall = 16'h0009; br_join = 16'h0333;
        ab_valid = 1; ab_mask = 4'hF; ab_begin = 16'h0200; ab_resume = 16'h0210;
        fire(); expect_main("R10", 16'h0200, 4'hF, 1);
        adv_valid = 1; adv_pc = 16'h0007;
        br_valid = 1; br_taken = 4'hF; br_target = 16'h0300; br_fall = 16'h0009; br_join = 16'h0333;
        fire(); expect_main("R10", 16'h0300, 4'hF, 1);
        check_state("R10");

        // R9 overflow on the shallow copy
        do_reset();
        do_br(4'h3, 16'h0010, 16'h0020, 16'h0030);
        check(s_depth == 3 && s_err == 0, "R9", "shallow depth", int'(s_depth), 3);
        do_br(4'h1, 16'h0014, 16'h0018, 16'h001C);
        check(s_err == 1, "R9", "err set", int'(s_err), 1);
        check(s_pc == 16'h0010 && s_mask == 4'h3, "R9", "pc unchanged", int'(s_pc), 16'h0010);
        check(s_depth == 3, "R9", "depth unchanged", int'(s_depth), 3);
        check_state("R9");
        do_adv(16'h001C);
        check(s_err == 1 && s_pc == 16'h001C, "R9", "sticky pc", int'(s_pc), 16'h001C);
        do_adv(16'h0030);
        check(s_err == 1, "R9", "sticky err", int'(s_err), 1);
        check(s_pc == 16'h0020 && s_mask == 4'hC && s_depth == 2, "R9", "pop after ovf",
              int'(s_pc), 16'h0020);
        check_state("R5");

        // Random mix, main instance against the model (R2 R3 R4 R5 R7 R8 R10)
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 4) begin
                adv_valid = 1;
                adv_pc = ($urandom_range(0, 9) < 4) ? m_join[m_cnt - 1] : PC_W'($urandom_range(0, 16'h0FFF));
            end else if (sel < 8) begin
                br_valid = 1;
                br_taken = 4'($urandom_range(0, 15));
                br_join = PC_W'(16'h1000 + 16 * $urandom_range(0, 7));
                br_target = ($urandom_range(0, 7) == 0) ? br_join : PC_W'($urandom_range(0, 16'h0FFF));
                br_fall = ($urandom_range(0, 7) == 0) ? br_join : PC_W'($urandom_range(0, 16'h0FFF));
                adv_valid = ($urandom_range(0, 3) == 0);
                adv_pc = PC_W'($urandom_range(0, 16'h0FFF));
            end else if (sel < 9) begin
                ab_valid = 1;
                ab_mask = 4'($urandom_range(0, 15));
                ab_begin = PC_W'($urandom_range(0, 16'h0FFF));
                ab_resume = PC_W'(16'h2000 + 16 * $urandom_range(0, 3));
                br_valid = ($urandom_range(0, 3) == 0);
            end
            fire();
            check_state("R4");
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule